// File: doc/BRIEF.md
# ADC Calibration Sequencer

This block runs the calibration phase of a slowly sampling converter. A rising edge on the calibrate strobe samples two select inputs and a polarity input. The selects pick one of four calibration kinds. For the chosen number of master clock cycles the block steers an input multiplexer to analog ground, to the reference, or to the analog input. While the multiplexer points at each source, the block records the accumulated filter result for that source. It then turns the recorded levels into an offset coefficient and a fixed-point gain coefficient.

While a calibration runs, the data-ready flag stays low. It goes high again in the same cycle the coefficients are written. Between calibrations the block corrects every raw sample with the stored coefficients. It subtracts the offset, multiplies by the gain, and clamps the result to the output range. In bipolar mode the calibrated zero point maps to midscale.

The modulator and the digital filter sit outside this block. A measurement input carries their settled result for whichever source the multiplexer currently selects.

Top module: `adc_cal_ctrl`

## Requirements
- R1: At a rising edge of `cal_req` the block samples `{sel_a,sel_b}` and `bipolar`. The kind is decoded as 00 self, 11 system zero step, 01 system gain step, 10 one-step system. `data_ready` falls at that edge and stays low for exactly T_SELF, T_SZ, T_SG or T_ONE cycles respectively.
- R2: Self calibration uses ground as its zero source and the reference as its full source. The offset becomes the ground level and the gain is computed from the reference level.
- R3: The system zero step keeps `src_sel` on the analog input throughout. The offset becomes the analog input level and the gain is left unchanged.
- R4: The system gain step keeps `src_sel` on the analog input throughout. The gain is computed from the analog input level against the stored offset, and the offset is left unchanged.
- R5: The one-step system calibration uses the analog input as its zero source and the reference as its full source. It writes both coefficients.
- R6: In a two-source calibration of length T, `src_sel` shows the zero source for the first floor(T/2)+1 cycles and the full source for the remaining cycles. The `src_sel` encoding is 0 ground, 1 reference, 2 analog input.
- R7: The gain is floor(S·2^GF / (F − Z)), where S is 2^DW−1 in unipolar mode and 2^(DW−1)−1 in bipolar mode, F is the full level and Z the zero level. If F ≤ Z, the gain is all ones.
- R8: Unipolar correction: `corr_out` = clamp(floor((raw − offset)·gain / 2^GF)) to the range 0 … 2^DW−1, one cycle after `raw_in`. A raw value at or below the offset gives 0, and a raw value above full scale gives all ones.
- R9: Bipolar correction adds 2^(DW−1) before clamping, so a raw value equal to the offset gives midscale. The polarity used for correction is the one sampled with the strobe, and it takes effect when that calibration completes.
- R10: A strobe edge while a calibration runs restarts the sequence with the newly sampled inputs. The low time of `data_ready` then becomes the elapsed cycles plus the full length of the new kind.
- R11: Coefficients change only at the completion edge. After reset the offset is 0, the gain is 2^GF (unity), `data_ready` is 1 and the mode is unipolar.
- R12: While idle, `src_sel` selects the analog input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cal_req | input | 1 | Calibrate strobe, acts on its rising edge |
| sel_a | input | 1 | First calibration select |
| sel_b | input | 1 | Second calibration select |
| bipolar | input | 1 | 1 = bipolar range, 0 = unipolar range |
| meas_in | input | DW | Settled filter result for the selected source |
| src_sel | output | 2 | Input multiplexer select: 0 ground, 1 reference, 2 analog input |
| raw_in | input | DW | Raw conversion result to be corrected |
| corr_out | output | DW | Corrected and clamped result |
| data_ready | output | 1 | High when no calibration is running |
| offset_coef | output | DW | Stored offset coefficient |
| gain_coef | output | DW+GF | Stored gain coefficient, GF fraction bits |

## Verification
The bench keeps DW=16 and GF=16, so the gain arithmetic runs at its full default width. It shrinks the four durations to 300, 101, 123 and 207 cycles. With these short runs the exact low time and the ground/reference/input cycle split of every kind can be counted, including odd and even lengths. The short runs also leave room for a mid-run restart and for many random calibrations, each followed by correction checks near zero, near full scale and beyond both.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

   typedef enum logic [1:0] {
      CK_SELF     = 2'b00,
      CK_SYS_GAIN = 2'b01,
      CK_SYS_ONE  = 2'b10,
      CK_SYS_ZERO = 2'b11
   } cal_kind_e;

   typedef enum logic [1:0] {
      SRC_GND = 2'd0,
      SRC_REF = 2'd1,
      SRC_AIN = 2'd2
   } src_e;

   function automatic logic kind_has_zero(cal_kind_e k);
      return (k != CK_SYS_GAIN);
   endfunction

   function automatic logic kind_has_full(cal_kind_e k);
      return (k != CK_SYS_ZERO);
   endfunction

endpackage

// File: rtl/cal_divider.sv
module cal_divider #(
   parameter int NW = 32,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] dvd,
   input  logic [DW-1:0] dsr,
   output logic [NW-1:0] quo
);
   localparam int SW = $clog2(NW + 1);

   logic [DW-1:0] rem_q, dsr_q;
   logic [NW-1:0] q_q;
   logic [SW-1:0] left_q;
   logic          run_q;
   logic [DW:0]   trial;
   logic          fits;

   always_comb begin
      trial = {rem_q, q_q[NW-1]};
      fits  = (trial >= {1'b0, dsr_q});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         dsr_q  <= '0;
         q_q    <= '0;
         left_q <= '0;
         run_q  <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         q_q    <= dvd;
         dsr_q  <= dsr;
         left_q <= SW'(NW);
         run_q  <= 1'b1;
      end else if (run_q) begin
         rem_q  <= fits ? DW'(trial - {1'b0, dsr_q}) : trial[DW-1:0];
         q_q    <= {q_q[NW-2:0], fits};
         left_q <= left_q - 1'b1;
         if (left_q == SW'(1)) run_q <= 1'b0;
      end
   end

   assign quo = q_q;

   // R7
   rem_below_dsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (rem_q < dsr_q));
   // R7
   nonzero_dsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (dsr != '0));

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
   import adc_cal_pkg::*;
#(
   parameter int DW      = 16,
   parameter int GF      = 16,
   parameter int T_SELF  = 3145655,
   parameter int T_SZ    = 1052599,
   parameter int T_SG    = 1068813,
   parameter int T_ONE   = 2117389
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cal_req,
   input  logic            sel_a,
   input  logic            sel_b,
   input  logic            bipolar,
   input  logic [DW-1:0]   meas_in,
   output logic [1:0]      src_sel,
   output logic            data_ready,
   output logic [DW-1:0]   offset_coef,
   output logic [DW+GF-1:0] gain_coef,
   output logic            bip_mode,
   output logic            div_start,
   output logic [DW+GF-1:0] div_dvd,
   output logic [DW-1:0]   div_dsr,
   input  logic [DW+GF-1:0] div_quo
);
   localparam int GW   = DW + GF;
   localparam int TM1  = (T_SELF > T_SZ) ? T_SELF : T_SZ;
   localparam int TM2  = (T_SG > T_ONE) ? T_SG : T_ONE;
   localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
   localparam int CW   = $clog2(TMAX + 1);
   localparam logic [DW-1:0] SPAN_UNI = {DW{1'b1}};
   localparam logic [DW-1:0] SPAN_BIP = {1'b0, {(DW-1){1'b1}}};

   function automatic logic [CW-1:0] dur_of(cal_kind_e k);
      case (k)
         CK_SELF:     return CW'(T_SELF);
         CK_SYS_ZERO: return CW'(T_SZ);
         CK_SYS_GAIN: return CW'(T_SG);
         default:     return CW'(T_ONE);
      endcase
   endfunction

   function automatic logic [CW-1:0] zero_pt(cal_kind_e k);
      case (k)
         CK_SELF:     return CW'(T_SELF / 2);
         CK_SYS_ONE:  return CW'(T_ONE / 2);
         CK_SYS_ZERO: return CW'(T_SZ - 2);
         default:     return '0;
      endcase
   endfunction

   function automatic logic [CW-1:0] full_pt(cal_kind_e k);
      return dur_of(k) - CW'(GW + 2);
   endfunction

   logic              req_q, busy_q, bip_pend_q, bip_q, bad_q;
   cal_kind_e         kind_q;
   logic [CW-1:0]     cnt_q, lim, zc, fc;
   logic [DW-1:0]     zero_q, off_q, base;
   logic [GW-1:0]     gain_q;
   logic signed [DW:0] fdiff;
   logic              req_edge, at_zero, at_full, at_end;

   always_comb begin
      req_edge = cal_req & ~req_q;
      lim      = dur_of(kind_q);
      zc       = zero_pt(kind_q);
      fc       = full_pt(kind_q);
      at_zero  = busy_q && kind_has_zero(kind_q) && (cnt_q == zc);
      at_full  = busy_q && kind_has_full(kind_q) && (cnt_q == fc);
      at_end   = busy_q && (cnt_q == lim - 1'b1);
      base     = (kind_q == CK_SYS_GAIN) ? off_q : zero_q;
      fdiff    = $signed({1'b0, meas_in}) - $signed({1'b0, base});
      div_start = at_full && !req_edge;
      div_dvd  = {(bip_pend_q ? SPAN_BIP : SPAN_UNI), {GF{1'b0}}};
      div_dsr  = (fdiff[DW] || fdiff == '0) ? DW'(1) : fdiff[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q      <= 1'b0;
         busy_q     <= 1'b0;
         kind_q     <= CK_SELF;
         bip_pend_q <= 1'b0;
         bip_q      <= 1'b0;
         bad_q      <= 1'b0;
         cnt_q      <= '0;
         zero_q     <= '0;
         off_q      <= '0;
         gain_q     <= GW'(1) << GF;
      end else begin
         req_q <= cal_req;
         if (req_edge) begin
            busy_q     <= 1'b1;
            kind_q     <= cal_kind_e'({sel_a, sel_b});
            bip_pend_q <= bipolar;
            cnt_q      <= '0;
         end else if (busy_q) begin
            if (at_zero) zero_q <= meas_in;
            if (at_full) bad_q  <= fdiff[DW] || (fdiff == '0);
            if (at_end) begin
               busy_q <= 1'b0;
               bip_q  <= bip_pend_q;
               if (kind_has_zero(kind_q)) off_q  <= zero_q;
               if (kind_has_full(kind_q)) gain_q <= bad_q ? {GW{1'b1}} : div_quo;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      if (!busy_q) src_sel = SRC_AIN;
      else begin
         case (kind_q)
            CK_SELF:    src_sel = (cnt_q <= zc) ? SRC_GND : SRC_REF;
            CK_SYS_ONE: src_sel = (cnt_q <= zc) ? SRC_AIN : SRC_REF;
            default:    src_sel = SRC_AIN;
         endcase
      end
   end

   assign data_ready  = !busy_q;
   assign offset_coef = off_q;
   assign gain_coef   = gain_q;
   assign bip_mode    = bip_q;

   // R1
   strobe_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cal_req) |=> !data_ready);
   // R11
   coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready && !req_edge) |=> ($stable(offset_coef) && $stable(gain_coef)));
   // R6
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q < lim));
   // R12
   idle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready |-> (src_sel == SRC_AIN));
   // R4
   gain_step_keeps_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && kind_q == CK_SYS_GAIN && !req_edge) |=> $stable(offset_coef));
   // R3
   zero_step_keeps_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && kind_q == CK_SYS_ZERO && !req_edge) |=> $stable(gain_coef));

endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
   parameter int DW = 16,
   parameter int GF = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   raw_in,
   input  logic [DW-1:0]   offset,
   input  logic [DW+GF-1:0] gain,
   input  logic            bip,
   output logic [DW-1:0]   corr_out
);
   localparam int GW = DW + GF;
   localparam int PW = DW + GW + 2;
   localparam logic signed [PW-1:0] MID  = {{(PW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
   localparam logic signed [PW-1:0] MAXV = {{(PW-DW){1'b0}}, {DW{1'b1}}};

   logic signed [DW:0]   diff;
   logic signed [PW-1:0] prod, scaled, biased;
   logic [DW-1:0]        clamped;

   always_comb begin
      diff   = $signed({1'b0, raw_in}) - $signed({1'b0, offset});
      prod   = diff * $signed({1'b0, gain});
      scaled = prod >>> GF;
      biased = scaled + (bip ? MID : '0);
      if (biased < 0)         clamped = '0;
      else if (biased > MAXV) clamped = {DW{1'b1}};
      else                    clamped = biased[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) corr_out <= '0;
      else        corr_out <= clamped;
   end

   // R8
   below_zero_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bip && raw_in <= offset) |=> (corr_out == '0));
   // R9
   bip_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bip && raw_in == offset) |=> (corr_out == MID[DW-1:0]));

endmodule

// File: rtl/adc_cal_ctrl.sv
module adc_cal_ctrl #(
   parameter int DW      = 16,
   parameter int GF      = 16,
   parameter int T_SELF  = 3145655,
   parameter int T_SZ    = 1052599,
   parameter int T_SG    = 1068813,
   parameter int T_ONE   = 2117389
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cal_req,
   input  logic             sel_a,
   input  logic             sel_b,
   input  logic             bipolar,
   input  logic [DW-1:0]    meas_in,
   output logic [1:0]       src_sel,
   input  logic [DW-1:0]    raw_in,
   output logic [DW-1:0]    corr_out,
   output logic             data_ready,
   output logic [DW-1:0]    offset_coef,
   output logic [DW+GF-1:0] gain_coef
);
   localparam int GW   = DW + GF;
   localparam int TMIN = 2 * GW + 8;

   generate
      if (DW < 4 || GF < 1) begin : g_bad_width
         $error("adc_cal_ctrl: DW must be at least 4 and GF at least 1");
      end
      if (T_SELF < TMIN || T_SZ < TMIN || T_SG < TMIN || T_ONE < TMIN) begin : g_bad_dur
         $error("adc_cal_ctrl: every duration must cover two capture windows and the divide");
      end
   endgenerate

   logic          bip_mode, div_start;
   logic [GW-1:0] div_dvd, div_quo;
   logic [DW-1:0] div_dsr;

   cal_sequencer #(
      .DW(DW), .GF(GF), .T_SELF(T_SELF), .T_SZ(T_SZ), .T_SG(T_SG), .T_ONE(T_ONE)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .sel_a(sel_a), .sel_b(sel_b),
      .bipolar(bipolar), .meas_in(meas_in), .src_sel(src_sel), .data_ready(data_ready),
      .offset_coef(offset_coef), .gain_coef(gain_coef), .bip_mode(bip_mode),
      .div_start(div_start), .div_dvd(div_dvd), .div_dsr(div_dsr), .div_quo(div_quo)
   );

   cal_divider #(.NW(GW), .DW(DW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .dvd(div_dvd), .dsr(div_dsr),
      .quo(div_quo)
   );

   cal_corrector #(.DW(DW), .GF(GF)) u_corr (
      .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .offset(offset_coef),
      .gain(gain_coef), .bip(bip_mode), .corr_out(corr_out)
   );

endmodule

// File: tb/adc_cal_ctrl_test.sv
module adc_cal_ctrl_test;
   localparam int CLK_P  = 10;
   localparam int DW     = 16;
   localparam int GF     = 16;
   localparam int T_SELF = 300;
   localparam int T_SZ   = 101;
   localparam int T_SG   = 123;
   localparam int T_ONE  = 207;

   logic clk = 0, rst_n = 0, cal_req = 0, sel_a = 0, sel_b = 0, bipolar = 0;
   logic [DW-1:0] meas_in, raw_in = 0, corr_out, offset_coef;
   logic [DW+GF-1:0] gain_coef;
   logic [1:0] src_sel;
   logic data_ready;
   logic [DW-1:0] vg = 0, vr = 0, va = 0;

   int checks = 0, failures = 0;
   longint e_off = 0, e_gain = 65536;
   bit e_bip = 0;

   always #(CLK_P/2) clk = ~clk;

   always_comb meas_in = (src_sel == 2'd0) ? vg : (src_sel == 2'd1) ? vr : va;

   adc_cal_ctrl #(.DW(DW), .GF(GF), .T_SELF(T_SELF), .T_SZ(T_SZ), .T_SG(T_SG),
                  .T_ONE(T_ONE)) uut (
      .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .sel_a(sel_a), .sel_b(sel_b),
      .bipolar(bipolar), .meas_in(meas_in), .src_sel(src_sel), .raw_in(raw_in),
      .corr_out(corr_out), .data_ready(data_ready), .offset_coef(offset_coef),
      .gain_coef(gain_coef));

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint dur(input int k);
      case (k) 0: return T_SELF; 3: return T_SZ; 1: return T_SG; default: return T_ONE; endcase
   endfunction

   function automatic longint calc_gain(input longint f, input longint z, input bit bip);
      longint span = bip ? 32767 : 65535;
      if (f <= z) return 64'hFFFF_FFFF;
      return (span << GF) / (f - z);
   endfunction

   function automatic longint calc_corr(input longint raw);
      longint p = ((raw - e_off) * e_gain) >>> GF;
      if (e_bip) p = p + 32768;
      if (p < 0) return 0;
      if (p > 65535) return 65535;
      return p;
   endfunction

   task automatic update_model(input int k, input bit bip);
      case (k)
         0: begin e_off = vg; e_gain = calc_gain(vr, vg, bip); end
         3: e_off = va;
         1: e_gain = calc_gain(va, e_off, bip);
         default: begin e_off = va; e_gain = calc_gain(vr, va, bip); end
      endcase
      e_bip = bip;
   endtask

   task automatic run_cal(input int k, input bit bip, input int rs_at, input int k2,
                          input bit bip2, output int lowc, output int gndc,
                          output int refc, output int ainc);
      lowc = 0; gndc = 0; refc = 0; ainc = 0;
      @(negedge clk);
      {sel_a, sel_b} = 2'(k); bipolar = bip; cal_req = 1;
      @(negedge clk);
      while (!data_ready && lowc < 5000) begin
         lowc++;
         if (src_sel == 2'd0) gndc++;
         else if (src_sel == 2'd1) refc++;
         else ainc++;
         if (lowc == rs_at) begin
            {sel_a, sel_b} = 2'(k2); bipolar = bip2; cal_req = 1;
         end else cal_req = 0;
         @(negedge clk);
      end
      cal_req = 0;
   endtask

   task automatic corr_chk(input string req, input longint raw);
      @(negedge clk); raw_in = DW'(raw);
      @(negedge clk);
      chk(req, corr_out, calc_corr(raw));
   endtask

   task automatic cal_and_check(input int k, input bit bip);
      int lc, gc, rc, ac;
      longint t = dur(k), z = dur(k) / 2;
      run_cal(k, bip, 0, 0, 0, lc, gc, rc, ac);
      chk("R1 low time", lc, t);
      case (k)
         0: begin chk("R6 ground cycles", gc, z + 1); chk("R2 reference cycles", rc, t - z - 1); end
         2: begin chk("R6 input cycles", ac, z + 1); chk("R5 reference cycles", rc, t - z - 1); end
         default: chk(k == 3 ? "R3 input-only" : "R4 input-only", ac, t);
      endcase
      update_model(k, bip);
      chk("R2 R3 R5 offset", offset_coef, e_off);
      chk("R7 R4 gain", gain_coef, e_gain);
   endtask

   initial begin
      #(CLK_P * 150000);
      failures++; checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int lc, gc, rc, ac;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 R12 reset state
      chk("R11 ready after reset", data_ready, 1);
      chk("R12 idle source", src_sel, 2);
      chk("R11 reset offset", offset_coef, 0);
      chk("R11 reset gain", gain_coef, 65536);
      corr_chk("R11 unity correction", 1234);

      // R2 self calibration, unipolar
      vg = 100; vr = 60000; va = 30000;
      cal_and_check(0, 0);
      corr_chk("R8 below offset", 50);
      corr_chk("R8 above full scale", 65000);
      corr_chk("R8 mid range", 30000);
      corr_chk("R8 at full level", 60000);

      // R3 system zero step
      va = 2000;
      cal_and_check(3, 0);
      // R4 system gain step
      va = 50000;
      cal_and_check(1, 0);
      corr_chk("R8 after two-step", 26000);

      // R5 one-step system, bipolar
      va = 5000; vr = 61000;
      cal_and_check(2, 1);
      corr_chk("R9 zero maps to midscale", 5000);
      corr_chk("R9 far below", 0);
      corr_chk("R9 upper", 60000);

      // R7 inverted levels give all-ones gain
      vg = 40000; vr = 30000;
      cal_and_check(0, 0);
      corr_chk("R7 R8 saturating gain", 40001);

      // R10 restart mid-run with a system zero step
      vg = 10; vr = 50000; va = 777;
      run_cal(0, 0, 50, 3, 1, lc, gc, rc, ac);
      chk("R10 restarted low time", lc, 50 + T_SZ);
      update_model(3, 1);
      chk("R10 offset after restart", offset_coef, e_off);
      corr_chk("R10 R9 mode after restart", 777);

      // random calibrations
      for (int i = 0; i < 24; i++) begin
         int k = int'($urandom % 4);
         bit b = 1'($urandom % 2);
         vg = DW'($urandom % 3000);
         vr = DW'(35000 + $urandom % 30000);
         va = DW'($urandom % 65536);
         cal_and_check(k, b);
         for (int j = 0; j < 4; j++) corr_chk("R8 R9 random", $urandom % 65536);
         corr_chk("R8 R9 at offset", e_off);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule